// File: doc/BRIEF.md
# Multi-Register Memory Transfer Sequencer

This block moves a chosen set of 32-bit registers between an external register file and memory, one 16-bit bus word at a time. A start pulse supplies a 16-bit select mask, a size (word or long), a direction, an addressing mode and a start address taken from one of the address registers. The sequencer then walks the selected registers, issues one read or write request per word, and waits for the bus acknowledge before it moves on.

Registers are read through a combinational read port and written through a single write port. That write port carries the loaded values during the transfer. It also carries the updated base register in the cycle after the last word, when the mode calls for a writeback. A one-cycle done pulse marks the end of every transfer, including an empty one.

Top module: `mrt_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are all low.
- R2: Mask bit i selects register i: indices 0 to 7 are the data registers and 8 to 15 are the address registers. In predecrement mode (`addr_mode` = 2) the registers are visited from index 15 down to 0. In plain indirect (0), postincrement (1) and the reserved code (3), which acts as plain indirect, they are visited from 0 up to 15.
- R3: With `size_long` = 0, each selected register takes one bus word, its low 16 bits. Addresses rise by 2 per word. In predecrement mode they fall by 2 instead, and the first word goes to the start address minus 2.
- R4: With `size_long` = 1, each register takes two words: high half first at the lower address, then low half at that address plus 2. Outside predecrement the addresses are consecutive from the start address. In predecrement mode the first word is at the start address minus 4, and the step is +2 after a high half and -6 after a low half.
- R5: With `to_mem` = 1 every request has `bus_we` high, and `bus_wdata` is the selected half of the register being stored.
- R6: A word load (`to_mem` = 0, `size_long` = 0) writes the sign-extended 16-bit read value into the register in the acknowledge cycle.
- R7: A long load writes the register once, after the second word, with the first word as bits 31:16 and the second as bits 15:0.
- R8: `bus_req`, `bus_addr` and `bus_we` hold steady until `bus_ack`. Each acknowledge completes exactly one word.
- R9: `done` is high for exactly one cycle, the cycle after the last acknowledge. In that cycle the write port puts the final base value into register 8 + `base_sel`: start + 2N for postincrement and start - 2N for predecrement, where N is the word count. Plain indirect writes nothing back.
- R10: An all-zero mask raises `done` in the cycle after `start`, with no bus request and no register write.
- R11: A `start` pulse while `busy` is high is ignored and does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled only while idle) |
| reg_mask | input | 16 | Register select mask |
| size_long | input | 1 | 0: word per register, 1: two words per register |
| to_mem | input | 1 | 1: registers to memory, 0: memory to registers |
| addr_mode | input | 2 | 0 plain, 1 postincrement, 2 predecrement, 3 as plain |
| base_sel | input | 3 | Address register holding the start address |
| base_addr | input | 32 | Start address (value of the base register) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Word access request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 32 | Byte address of the word |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access completed |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |

## Verification
The bench builds the block with its default parameters: sixteen registers and 16-bit words. At these sizes a full mask in long size produces the maximum of 32 words, and the predecrement -6 step is hit sixteen times in one run. Acknowledge latencies of zero to three cycles show that a request is held while it waits. A second start pulse during a slow one-word transfer shows that a running sequence cannot be restarted. Loads from a memory pattern with the sign bit both set and clear expose the sign extension.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_RSVD    = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/mrt_pick.sv
// Selects the next register from a mask: lowest set bit when walking
// upward, highest set bit when walking downward.
module mrt_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0]         mask,
    input  logic                 from_top,
    output logic [$clog2(N)-1:0] idx,
    output logic                 found
);
    localparam int IW = $clog2(N);

    always_comb begin
        idx   = '0;
        found = |mask;
        if (from_top) begin
            for (int i = 0; i < N; i++) begin
                if (mask[i]) idx = IW'(i);
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (mask[i]) idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mrt_step.sv
// Address increment applied after each completed word.
module mrt_step #(
    parameter int AW = 32,
    parameter int WB = 2
) (
    input  logic          long_x,
    input  logic          predec,
    input  logic          low_half,
    output logic [AW-1:0] delta
);
    localparam logic [AW-1:0] UP_ONE   = AW'(WB);
    localparam logic [AW-1:0] DOWN_ONE = AW'(-WB);
    localparam logic [AW-1:0] DOWN_TRI = AW'(-3 * WB);

    always_comb begin
        if (!long_x)       delta = predec ? DOWN_ONE : UP_ONE;
        else if (!low_half) delta = UP_ONE;
        else               delta = predec ? DOWN_TRI : UP_ONE;
    end

endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
    import mrt_pkg::*;
#(
    parameter int REG_CNT = 16,
    parameter int WORD_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [REG_CNT-1:0]           reg_mask,
    input  logic                         size_long,
    input  logic                         to_mem,
    input  logic [1:0]                   addr_mode,
    input  logic [$clog2(REG_CNT)-2:0]   base_sel,
    input  logic [2*WORD_W-1:0]          base_addr,
    output logic                         busy,
    output logic                         done,
    output logic                         bus_req,
    output logic                         bus_we,
    output logic [2*WORD_W-1:0]          bus_addr,
    output logic [WORD_W-1:0]            bus_wdata,
    input  logic                         bus_ack,
    input  logic [WORD_W-1:0]            bus_rdata,
    output logic [$clog2(REG_CNT)-1:0]   rf_rd_idx,
    input  logic [2*WORD_W-1:0]          rf_rd_data,
    output logic                         rf_wr_en,
    output logic [$clog2(REG_CNT)-1:0]   rf_wr_idx,
    output logic [2*WORD_W-1:0]          rf_wr_data
);
    localparam int IW = $clog2(REG_CNT);
    localparam int RW = 2 * WORD_W;
    localparam int WB = WORD_W / 8;
    localparam int CW = $clog2(2 * REG_CNT + 1);

    typedef struct packed {
        seq_state_e          st;
        logic [REG_CNT-1:0]  left;
        logic [IW-1:0]       cur;
        logic                low;
        logic                lng;
        logic                wr;
        addr_mode_e          mode;
        logic [IW-2:0]       bsel;
        logic [RW-1:0]       addr;
        logic [RW-1:0]       fin_addr;
        logic                wb;
        logic [WORD_W-1:0]   hold;
        logic [CW-1:0]       pos;
        logic [CW-1:0]       cnt;
    } seq_t;

    seq_t q, d;

    logic [REG_CNT-1:0] pick_mask;
    logic               pick_top;
    logic [IW-1:0]      pick_idx;
    logic               pick_found;
    logic [RW-1:0]      step;
    logic [CW-1:0]      nsel_d;
    logic [CW-1:0]      nwords_d;
    logic [RW-1:0]      span_d;
    logic               start_pre;
    logic               load_commit;
    logic               base_commit;

    assign start_pre = (addr_mode_e'(addr_mode) == AM_PREDEC);
    assign pick_mask = (q.st == SQ_IDLE) ? reg_mask : q.left;
    assign pick_top  = (q.st == SQ_IDLE) ? start_pre : (q.mode == AM_PREDEC);

    mrt_pick #(.N(REG_CNT)) pick_i (
        .mask     (pick_mask),
        .from_top (pick_top),
        .idx      (pick_idx),
        .found    (pick_found)
    );

    mrt_step #(.AW(RW), .WB(WB)) step_i (
        .long_x   (q.lng),
        .predec   (q.mode == AM_PREDEC),
        .low_half (q.low),
        .delta    (step)
    );

    always_comb begin
        nsel_d = '0;
        for (int i = 0; i < REG_CNT; i++) begin
            nsel_d = nsel_d + CW'(reg_mask[i]);
        end
        nwords_d = size_long ? (nsel_d << 1) : nsel_d;
        span_d   = RW'(nwords_d) * RW'(WB);
    end

    always_comb begin
        d = q;
        unique case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.left  = reg_mask & ~(REG_CNT'(1) << pick_idx);
                    d.cur   = pick_idx;
                    d.low   = 1'b0;
                    d.lng   = size_long;
                    d.wr    = to_mem;
                    d.mode  = addr_mode_e'(addr_mode);
                    d.bsel  = base_sel;
                    d.pos   = '0;
                    d.cnt   = nwords_d;
                    if (start_pre) begin
                        d.addr     = base_addr - (size_long ? RW'(2 * WB) : RW'(WB));
                        d.fin_addr = base_addr - span_d;
                    end else begin
                        d.addr     = base_addr;
                        d.fin_addr = base_addr + span_d;
                    end
                    d.wb = pick_found &&
                           (addr_mode_e'(addr_mode) == AM_POSTINC || start_pre);
                    d.st = pick_found ? SQ_XFER : SQ_FIN;
                end
            end
            SQ_XFER: begin
                if (bus_ack) begin
                    if (!q.low) d.hold = bus_rdata;
                    d.pos  = q.pos + CW'(1);
                    d.addr = q.addr + step;
                    if (q.pos + CW'(1) == q.cnt) begin
                        d.st = SQ_FIN;
                    end else if (q.lng && !q.low) begin
                        d.low = 1'b1;
                    end else begin
                        d.low  = 1'b0;
                        d.cur  = pick_idx;
                        d.left = q.left & ~(REG_CNT'(1) << pick_idx);
                    end
                end
            end
            SQ_FIN:  d.st = SQ_IDLE;
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != SQ_IDLE);
    assign done      = (q.st == SQ_FIN);
    assign bus_req   = (q.st == SQ_XFER);
    assign bus_we    = q.wr;
    assign bus_addr  = q.addr;
    assign bus_wdata = (q.lng && !q.low) ? rf_rd_data[RW-1:WORD_W] : rf_rd_data[WORD_W-1:0];
    assign rf_rd_idx = q.cur;

    assign load_commit = bus_req && bus_ack && !q.wr && (!q.lng || q.low);
    assign base_commit = done && q.wb;
    assign rf_wr_en    = load_commit || base_commit;
    assign rf_wr_idx   = base_commit ? {1'b1, q.bsel} : q.cur;
    assign rf_wr_data  = base_commit ? q.fin_addr :
                         (q.lng ? {q.hold, bus_rdata}
                                : {{WORD_W{bus_rdata[WORD_W-1]}}, bus_rdata});

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)) // R8
        else $error("request dropped or changed before acknowledge");

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R9
        else $error("done held longer than one cycle");

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (reg_mask == '0) |=> done && !rf_wr_en && !bus_req) // R10
        else $error("empty mask did not complete cleanly");

    AST_STORE_NO_RFWR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> !rf_wr_en) // R5
        else $error("register write during store");

    AST_LOAD_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en && !done |-> bus_ack && !bus_we) // R6
        else $error("register load outside an acknowledged read");

endmodule

// File: tb/mrt_seq_tb.sv
`timescale 1ns/1ps
module mrt_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] m_drv = '0;
    logic        lg_drv = 1'b0;
    logic        st_drv = 1'b0;
    logic [1:0]  md_drv = '0;
    logic [2:0]  bs_drv = '0;
    logic [31:0] ba_drv;
    logic        busy, done, bus_req, bus_we, rf_wr_en;
    logic [31:0] bus_addr, rf_rd_data, rf_wr_data;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic [3:0]  rf_rd_idx, rf_wr_idx;

    logic [31:0] rf [16];
    logic [31:0] rf_init [16];
    logic [15:0] mem [256];
    logic [15:0] mem_init [256];
    logic        pl_all = 1'b0;

    logic [31:0] log_addr [256];
    logic        log_we [256];
    logic [15:0] log_wd [256];
    int          log_n = 0;
    int          last_ack_cyc = 0;
    int          done_cnt = 0;
    int          done_cyc = 0;
    logic        done_wb = 1'b0;
    logic [3:0]  done_idx = '0;
    logic [31:0] done_data = '0;
    int          lat = 0;
    int          wcnt = 0;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    assign ba_drv     = rf[8 + bs_drv];
    assign rf_rd_data = rf[rf_rd_idx];

    mrt_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(m_drv),
        .size_long(lg_drv), .to_mem(st_drv), .addr_mode(md_drv),
        .base_sel(bs_drv), .base_addr(ba_drv), .busy(busy), .done(done),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pl_all) begin
            for (int i = 0; i < 16; i++) rf[i] <= rf_init[i];
        end else if (rf_wr_en) begin
            rf[rf_wr_idx] <= rf_wr_data;
        end
    end

    // Memory model with programmable acknowledge latency and a transaction log
    always @(negedge clk) begin
        if (pl_all) begin
            for (int i = 0; i < 256; i++) mem[i] = mem_init[i];
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (bus_req) begin
            if (wcnt >= lat) begin
                bus_ack = 1'b1;
                bus_rdata = mem[bus_addr[8:1]];
                log_addr[log_n] = bus_addr;
                log_we[log_n] = bus_we;
                log_wd[log_n] = bus_wdata;
                log_n = log_n + 1;
                if (bus_we) mem[bus_addr[8:1]] = bus_wdata;
                last_ack_cyc = cyc;
            end else begin
                wcnt = wcnt + 1;
            end
        end
        if (done) begin
            done_cyc  = cyc;
            done_wb   = rf_wr_en;
            done_idx  = rf_wr_idx;
            done_data = rf_wr_data;
            done_cnt  = done_cnt + 1;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic load_state();
        @(negedge clk);
        pl_all = 1'b1;
        @(negedge clk);
        pl_all = 1'b0;
    endtask

    task automatic run_xfer(input string t_ord, input string t_dat,
                            input logic [15:0] m, input logic lg, input logic st,
                            input logic [1:0] md, input logic [2:0] bs,
                            input logic [31:0] base, input int latency,
                            input int extra_starts);
        logic [31:0] ea [32];
        logic [15:0] ed [32];
        logic [31:0] exp_rf [16];
        logic [31:0] a;
        logic [31:0] exp_base;
        logic        exp_wb;
        int n, j, w, l0, d0, s_cyc, r;
        rf_init[8 + bs] = base;
        load_state();
        n = 0; j = 0; w = lg ? 2 : 1;
        for (int i = 0; i < 16; i++) exp_rf[i] = rf_init[i];
        for (int t = 0; t < 16; t++) begin
            r = (md == 2'd2) ? 15 - t : t;
            if (m[r]) begin
                for (int h = 0; h < w; h++) begin
                    if (md == 2'd2) a = base - 32'((j + 1) * w * 2) + 32'(h * 2);
                    else            a = base + 32'(n * 2);
                    ea[n] = a;
                    ed[n] = (lg && h == 0) ? rf_init[r][31:16] : rf_init[r][15:0];
                    if (!lg)        exp_rf[r] = {{16{mem_init[a[8:1]][15]}}, mem_init[a[8:1]]};
                    else if (h == 0) exp_rf[r][31:16] = mem_init[a[8:1]];
                    else            exp_rf[r][15:0] = mem_init[a[8:1]];
                    n++;
                end
                j++;
            end
        end
        if (st) begin
            for (int i = 0; i < 16; i++) exp_rf[i] = rf_init[i];
        end
        exp_wb = (n != 0) && (md == 2'd1 || md == 2'd2);
        exp_base = (md == 2'd2) ? base - 32'(2 * n) : base + 32'(2 * n);
        if (exp_wb) exp_rf[8 + bs] = exp_base;

        l0 = log_n; d0 = done_cnt; lat = latency;
        @(negedge clk);
        m_drv = m; lg_drv = lg; st_drv = st; md_drv = md; bs_drv = bs; start = 1'b1;
        s_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (extra_starts > 0) begin
            m_drv = 16'hFFFF; md_drv = 2'd1; lg_drv = 1'b1; start = 1'b1;
            repeat (extra_starts) @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);

        chk(t_ord, "word count", 32'(log_n - l0), 32'(n));
        for (int k = 0; k < n; k++) begin
            chk(t_ord, $sformatf("address of word %0d", k), log_addr[l0 + k], ea[k]);
            chk(t_dat, $sformatf("direction of word %0d", k), 32'(log_we[l0 + k]), 32'(st));
            if (st) chk(t_dat, $sformatf("store data word %0d", k), 32'(log_wd[l0 + k]), 32'(ed[k]));
        end
        if (n == 0) chk("R10", "done cycle after start", 32'(done_cyc), 32'(s_cyc + 1));
        else        chk("R9", "done cycle after last ack", 32'(done_cyc), 32'(last_ack_cyc + 1));
        chk("R9", "single done pulse", 32'(done_cnt - d0), 32'd1);
        chk("R9", "base writeback flag", 32'(done_wb), 32'(exp_wb));
        if (exp_wb) begin
            chk("R9", "base writeback index", 32'(done_idx), 32'(8 + bs));
            chk("R9", "base writeback value", done_data, exp_base);
        end
        for (int i = 0; i < 16; i++) begin
            chk(t_dat, $sformatf("register %0d after transfer", i), rf[i], exp_rf[i]);
        end
        chk("R9", "idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            rf_init[i] = {8'(8'hA0 + i), 8'h91, 8'(8'h70 + i), 8'(8'h0F ^ i)};
            rf[i] = rf_init[i];
        end
        for (int i = 0; i < 256; i++) begin
            mem_init[i] = {~8'(i), 8'(i)};
            mem[i] = mem_init[i];
        end
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        chk("R1", "done after reset", 32'(done), 32'd0);
        chk("R1", "bus_req after reset", 32'(bus_req), 32'd0);

        // word store, postincrement, ascending order
        run_xfer("R2 R3", "R5", 16'h8101, 1'b0, 1'b1, 2'd1, 3'd1, 32'h40, 0, 0);
        // long store, predecrement, descending order, slow acknowledge
        run_xfer("R2 R4 R8", "R5", 16'h8003, 1'b1, 1'b1, 2'd2, 3'd6, 32'h100, 2, 0);
        // word store, predecrement
        run_xfer("R2 R3", "R5", 16'h0300, 1'b0, 1'b1, 2'd2, 3'd5, 32'h60, 1, 0);
        // word load with sign extension, plain indirect (no writeback)
        run_xfer("R3 R8", "R6", 16'h0240, 1'b0, 1'b0, 2'd0, 3'd2, 32'hFE, 1, 0);
        // long load, postincrement
        run_xfer("R4 R8", "R7", 16'h0420, 1'b1, 1'b0, 2'd1, 3'd0, 32'h120, 3, 0);
        // long load of all data registers, reserved mode acts as plain
        run_xfer("R2 R4", "R7", 16'h00FF, 1'b1, 1'b0, 2'd3, 3'd5, 32'h10, 0, 0);
        // empty mask
        run_xfer("R10", "R10", 16'h0000, 1'b0, 1'b1, 2'd1, 3'd3, 32'h80, 0, 0);
        // start pulses while busy are ignored
        run_xfer("R11", "R11", 16'h0001, 1'b0, 1'b1, 2'd0, 3'd4, 32'hC0, 3, 2);
        // full mask, long, predecrement: 32 words
        run_xfer("R2 R4", "R5", 16'hFFFF, 1'b1, 1'b1, 2'd2, 3'd7, 32'h1F0, 0, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule